// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is one programmable logic cell of a small product-term device. A bank of AND terms is built over 22 literals: the 18 data inputs and the four macrocell register states fed back. Each of the four outputs is formed in one of two ways. The short route ORs a fixed group of four terms. The long route ORs any chosen subset of twenty shared terms and then passes the result through an XOR with a polarity bit. The output then leaves either directly or through a D flip-flop. Three extra control terms can clear the registers asynchronously, drive the output enables, and serve as the register clock.

The function is set by a 1111-bit configuration that is written in 32-bit words while the block is held in reset. The clock for all four registers is chosen once per block from three dedicated clock pins or from the clock term. The active-low reset input clears every register. Its release is synchronised to `clk_y0`.

Top module: `ptlb_top`

## Requirements
- R1: Literal i (0..17) is `din[i]`. Literal 18+k is the register state of macrocell k. A registered output can therefore drive the terms that are evaluated at the next clock.
- R2: Term j has a true-enable mask at configuration bits 44j..44j+21 and a complement-enable mask at 44j+22..44j+43, with bit offset = literal index. A term is 0 when any literal has both enables set, or when no enable is set at all, so an unused term never adds a 1.
- R3: On the short route, output k is the OR of terms 4k..4k+3. On this route the share mask and the polarity bit have no effect.
- R4: On the long route, output k is the OR of the terms 0..19 whose bits are set in its share mask, XORed with its polarity bit. One term may feed several outputs.
- R5: Each output has a 23-bit field at bit 1012+23k: bits 0..19 share mask, bit 20 long-route select, bit 21 polarity, bit 22 registered select. When registered select is 0, the output is the sum directly. When it is 1, the output is the register, which captures the sum.
- R6: Bits 1104..1105 choose the register clock: 0 = `clk_y0`, 1 = `clk_y1`, 2 = `clk_y2`, 3 = the rising edge of clock term 22. Edges on the sources that are not selected have no effect.
- R7: When bit 1106 is set, reset term 20 clears all four registers asynchronously and holds them clear for as long as the term is 1.
- R8: Bits 1107+k select, for output k, whether `dout_oe[k]` follows enable term 21 (bit set) or stays at 1 (bit clear).
- R9: While `rst_n` is low, all registers read 0. After `rst_n` rises, the registers stay cleared until two rising edges of `clk_y0` have passed.
- R10: A write with `cfg_we` high stores `cfg_wdata` into configuration bits 32a..32a+31 for address a (0..34) at a rising edge of `clk_y0`, but only while the internal reset is held. Writes at any other time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_y0 | input | 1 | Dedicated clock 0; also clocks configuration writes and reset release |
| clk_y1 | input | 1 | Dedicated clock 1 |
| clk_y2 | input | 1 | Dedicated clock 2 |
| rst_n | input | 1 | Active-low global reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration word data |
| din | input | 18 | Data inputs to the term array |
| dout | output | 4 | Macrocell outputs |
| dout_oe | output | 4 | Per-output enable passed to the pad cell |

## Verification
The bench targets several behaviours that a faulty design would get visibly wrong:
- Terms with no literals and terms with a literal enabled in both polarities must read 0. A design that let them through would invert a polarity-1 sum or turn an impossible AND into a live one.
- A term shared between a short-route output and a long-route output must reach both. A term that sits in a long-route output's own bypass group must be ignored.
- A two-stage shift through the feedback literal exposes wrong feedback ordering. The same stimulus also exposes a missing register or an extra one.
- Clock sources that are not selected must be ignored, and the clock term must capture on its rising edge only. The reset term must clear the registers even while clocks keep running. A configuration write issued after reset release would show up as a lost term on the next clock.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  typedef enum logic [1:0] {
    CLK_Y0 = 2'd0,
    CLK_Y1 = 2'd1,
    CLK_Y2 = 2'd2,
    CLK_PT = 2'd3
  } clk_src_e;

  // Control terms follow the shared sum terms in this order.
  localparam int unsigned CTL_RST = 0;
  localparam int unsigned CTL_OE  = 1;
  localparam int unsigned CTL_CLK = 2;
  localparam int unsigned N_CTL   = 3;

  // Global field: clock select, reset-term enable, then per-output OE enables.
  localparam int unsigned GLB_SRC_W = 2;

endpackage

// File: rtl/ptlb_cfg_store.sv
module ptlb_cfg_store #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned TOTAL_BITS = 1111,
  parameter int unsigned N_WORDS    = (TOTAL_BITS + WORD_W - 1) / WORD_W,
  parameter int unsigned ADDR_W     = $clog2(N_WORDS)
) (
  input  logic                  clk,
  input  logic                  wr_allow,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [TOTAL_BITS-1:0] cfg
);

  generate
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      localparam int unsigned LO = w * WORD_W;
      localparam int unsigned HI = ((LO + WORD_W) < TOTAL_BITS) ? (LO + WORD_W - 1) : (TOTAL_BITS - 1);
      localparam int unsigned WW = HI - LO + 1;

      logic          hit;
      logic [WW-1:0] word_q;
      logic [WW-1:0] word_d;

      assign hit = we && wr_allow && (addr == ADDR_W'(w));

      always_comb begin
        word_d = word_q;
        if (hit) begin
          word_d = wdata[WW-1:0];
        end
      end

      always_ff @(posedge clk) begin
        if (hit) begin
          word_q <= word_d;
        end
      end

      assign cfg[HI:LO] = word_q;
    end
  endgenerate

endmodule

// File: rtl/ptlb_and_array.sv
module ptlb_and_array #(
  parameter int unsigned N_LIT   = 22,
  parameter int unsigned N_TERMS = 23,
  localparam int unsigned TERM_W = 2 * N_LIT
) (
  input  logic [N_LIT-1:0]          lit,
  input  logic [N_TERMS*TERM_W-1:0] tcfg,
  output logic [N_TERMS-1:0]        pt
);

  generate
    for (genvar j = 0; j < N_TERMS; j++) begin : g_term
      logic [N_LIT-1:0] t_en;
      logic [N_LIT-1:0] c_en;
      logic [N_LIT-1:0] pass;
      logic             used;

      assign t_en = tcfg[j*TERM_W +: N_LIT];
      assign c_en = tcfg[j*TERM_W + N_LIT +: N_LIT];
      // A literal passes when each enabled polarity agrees with it.
      assign pass = (~t_en | lit) & (~c_en | ~lit);
      assign used = |(t_en | c_en);
      assign pt[j] = used & (&pass);
    end
  endgenerate

endmodule

// File: rtl/ptlb_macrocell.sv
module ptlb_macrocell #(
  parameter int unsigned N_SUM = 20,
  parameter int unsigned N_BYP = 4,
  parameter int unsigned IDX   = 0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [N_SUM-1:0] pt,
  input  logic [N_SUM-1:0] share_mask,
  input  logic             route_wide,
  input  logic             polarity,
  input  logic             registered,
  output logic             d_sum,
  output logic             q,
  output logic             dout
);

  localparam int unsigned BYP_LO = IDX * N_BYP;

  logic byp_sum;
  logic wide_sum;
  logic q_d;

  assign byp_sum  = |pt[BYP_LO +: N_BYP];
  assign wide_sum = (|(pt & share_mask)) ^ polarity;
  assign d_sum    = route_wide ? wide_sum : byp_sum;

  always_comb begin
    q_d = d_sum;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_d;
    end
  end

  assign dout = registered ? q : d_sum;

endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
  import ptlb_pkg::*;
#(
  parameter int unsigned N_DIN  = 18,
  parameter int unsigned N_MC   = 4,
  parameter int unsigned N_SUM  = 20,
  parameter int unsigned N_BYP  = 4,
  parameter int unsigned CFG_W  = 32,
  localparam int unsigned N_LIT    = N_DIN + N_MC,
  localparam int unsigned TERM_W   = 2 * N_LIT,
  localparam int unsigned N_PT_ALL = N_SUM + N_CTL,
  localparam int unsigned PT_AREA  = N_PT_ALL * TERM_W,
  localparam int unsigned MC_FLD   = N_SUM + 3,
  localparam int unsigned MC_LO    = PT_AREA,
  localparam int unsigned GLB_LO   = MC_LO + N_MC * MC_FLD,
  localparam int unsigned CFG_BITS = GLB_LO + GLB_SRC_W + 1 + N_MC,
  localparam int unsigned N_WORDS  = (CFG_BITS + CFG_W - 1) / CFG_W,
  localparam int unsigned ADDR_W   = $clog2(N_WORDS)
) (
  input  logic              clk_y0,
  input  logic              clk_y1,
  input  logic              clk_y2,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [N_DIN-1:0]  din,
  output logic [N_MC-1:0]   dout,
  output logic [N_MC-1:0]   dout_oe
);

  // Reset: asserted asynchronously, released after two clk_y0 edges.
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_d;
  logic       rst_sync_n;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[0], 1'b1};
  end

  always_ff @(posedge clk_y0 or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // Configuration storage, writable only while held in reset.
  logic [CFG_BITS-1:0] cfg_vec;

  ptlb_cfg_store #(
    .WORD_W     (CFG_W),
    .TOTAL_BITS (CFG_BITS),
    .N_WORDS    (N_WORDS),
    .ADDR_W     (ADDR_W)
  ) cfg_i (
    .clk      (clk_y0),
    .wr_allow (~rst_sync_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .cfg      (cfg_vec)
  );

  // Field decode.
  logic [PT_AREA-1:0] term_cfg;
  clk_src_e           clk_src;
  logic               rst_pt_en;
  logic [N_MC-1:0]    oe_pt_en;

  assign term_cfg  = cfg_vec[PT_AREA-1:0];
  assign clk_src   = clk_src_e'(cfg_vec[GLB_LO +: GLB_SRC_W]);
  assign rst_pt_en = cfg_vec[GLB_LO + GLB_SRC_W];
  assign oe_pt_en  = cfg_vec[GLB_LO + GLB_SRC_W + 1 +: N_MC];

  // Term array over data inputs and register feedback.
  logic [N_MC-1:0]     mc_q;
  logic [N_MC-1:0]     mc_d;
  logic [N_LIT-1:0]    lit;
  logic [N_PT_ALL-1:0] pt_all;
  logic [N_SUM-1:0]    pt_sum;
  logic                pt_rst;
  logic                pt_oe;
  logic                pt_clk;

  assign lit = {mc_q, din};

  ptlb_and_array #(
    .N_LIT   (N_LIT),
    .N_TERMS (N_PT_ALL)
  ) and_i (
    .lit  (lit),
    .tcfg (term_cfg),
    .pt   (pt_all)
  );

  assign pt_sum = pt_all[N_SUM-1:0];
  assign pt_rst = pt_all[N_SUM + CTL_RST];
  assign pt_oe  = pt_all[N_SUM + CTL_OE];
  assign pt_clk = pt_all[N_SUM + CTL_CLK];

  // Block clock select.
  logic blk_clk;

  always_comb begin
    case (clk_src)
      CLK_Y0:  blk_clk = clk_y0;
      CLK_Y1:  blk_clk = clk_y1;
      CLK_Y2:  blk_clk = clk_y2;
      default: blk_clk = pt_clk;
    endcase
  end

  // Register clear: global reset or enabled reset term.
  logic mc_rst_n;
  assign mc_rst_n = rst_sync_n & ~(rst_pt_en & pt_rst);

  generate
    for (genvar k = 0; k < N_MC; k++) begin : g_mc
      localparam int unsigned F = MC_LO + k * MC_FLD;

      ptlb_macrocell #(
        .N_SUM (N_SUM),
        .N_BYP (N_BYP),
        .IDX   (k)
      ) mc_i (
        .clk        (blk_clk),
        .arst_n     (mc_rst_n),
        .pt         (pt_sum),
        .share_mask (cfg_vec[F +: N_SUM]),
        .route_wide (cfg_vec[F + N_SUM]),
        .polarity   (cfg_vec[F + N_SUM + 1]),
        .registered (cfg_vec[F + N_SUM + 2]),
        .d_sum      (mc_d[k]),
        .q          (mc_q[k]),
        .dout       (dout[k])
      );

      assign dout_oe[k] = oe_pt_en[k] ? pt_oe : 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ptlb_checker.sv
module ptlb_checker #(
  parameter int unsigned N_LIT    = 22,
  parameter int unsigned N_TERMS  = 23,
  parameter int unsigned N_MC     = 4,
  parameter int unsigned CFG_BITS = 1111,
  localparam int unsigned TERM_W  = 2 * N_LIT
) (
  input logic                      clk_y0,
  input logic                      rst_n,
  input logic                      rst_sync_n,
  input logic [CFG_BITS-1:0]       cfg_vec,
  input logic [N_TERMS*TERM_W-1:0] term_cfg,
  input logic [N_TERMS-1:0]        pt_all,
  input logic                      mc_rst_n,
  input logic [N_MC-1:0]           mc_q,
  input logic [N_MC-1:0]           mc_d,
  input logic [1:0]                clk_src
);

  // R10: configuration cannot move once reset has been released.
  a_r10_cfg_frozen: assert property (@(posedge clk_y0) disable iff (!rst_n)
    (rst_sync_n && $past(rst_sync_n)) |-> $stable(cfg_vec));

  // R9: internal release only follows a high reset input.
  a_r9_sync_release: assert property (@(posedge clk_y0) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n));

  // R7 / R9: a held clear keeps every register at 0.
  a_r7_clear_holds: assert property (@(posedge clk_y0) disable iff (!rst_n)
    (!mc_rst_n) |-> (mc_q == '0));

  // R6: with clk_y0 selected, registers take the sum seen at the previous edge.
  a_r6_y0_capture: assert property (@(posedge clk_y0) disable iff (!rst_n)
    (clk_src == 2'd0 && mc_rst_n && $past(mc_rst_n) && $past(clk_src) == 2'd0)
      |-> (mc_q == $past(mc_d)));

  // R2: conflicting or empty terms read 0.
  generate
    for (genvar j = 0; j < N_TERMS; j++) begin : g_term
      logic [N_LIT-1:0] t_en;
      logic [N_LIT-1:0] c_en;
      assign t_en = term_cfg[j*TERM_W +: N_LIT];
      assign c_en = term_cfg[j*TERM_W + N_LIT +: N_LIT];

      a_r2_term_zero: assert property (@(posedge clk_y0) disable iff (!rst_n)
        ((|(t_en & c_en)) || !(|(t_en | c_en))) |-> !pt_all[j]);
    end
  endgenerate

endmodule

bind ptlb_top ptlb_checker #(
  .N_LIT    (N_LIT),
  .N_TERMS  (N_PT_ALL),
  .N_MC     (N_MC),
  .CFG_BITS (CFG_BITS)
) chk_i (
  .clk_y0     (clk_y0),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .cfg_vec    (cfg_vec),
  .term_cfg   (term_cfg),
  .pt_all     (pt_all),
  .mc_rst_n   (mc_rst_n),
  .mc_q       (mc_q),
  .mc_d       (mc_d),
  .clk_src    (clk_src)
);

// File: tb/ptlb_top_tb_top.sv
module ptlb_top_tb_top;

  localparam int N_LIT   = 22;
  localparam int TERM_W  = 44;
  localparam int MC_BASE = 1012;
  localparam int MC_FLD  = 23;
  localparam int GLB     = 1104;
  localparam int N_WORDS = 35;

  logic        clk_y0 = 1'b0;
  logic        clk_y1 = 1'b0;
  logic        clk_y2 = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [17:0] din;
  logic [3:0]  dout;
  logic [3:0]  dout_oe;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [N_WORDS*32-1:0] cv;

  always #5 clk_y0 = ~clk_y0;

  ptlb_top dut_i (
    .clk_y0    (clk_y0),
    .clk_y1    (clk_y1),
    .clk_y2    (clk_y2),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .din       (din),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  // {din, dout, dout_oe} for the combinational configuration.
  localparam logic [25:0] TBL [13] = '{
    {18'h00000, 4'b0110, 4'b0111},
    {18'h00003, 4'b0101, 4'b0111},
    {18'h00008, 4'b0111, 4'b0111},
    {18'h0000C, 4'b0110, 4'b0111},
    {18'h00030, 4'b0110, 4'b0111},
    {18'h001C0, 4'b0100, 4'b0111},
    {18'h20000, 4'b0100, 4'b0111},
    {18'h00200, 4'b0010, 4'b0111},
    {18'h00800, 4'b0110, 4'b0111},
    {18'h01000, 4'b1110, 4'b0111},
    {18'h1C000, 4'b1110, 4'b1111},
    {18'h0A000, 4'b0110, 4'b1111},
    {18'h3FFFF, 4'b1001, 4'b1111}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic lit_on(input int term, input int li, input bit comp);
    cv[term*TERM_W + (comp ? N_LIT : 0) + li] = 1'b1;
  endtask

  task automatic mc_set(input int k, input logic [19:0] mask, input bit wide, input bit pol, input bit regd);
    int base;
    base = MC_BASE + k*MC_FLD;
    for (int i = 0; i < 20; i++) cv[base+i] = mask[i];
    cv[base+20] = wide;
    cv[base+21] = pol;
    cv[base+22] = regd;
  endtask

  task automatic glb_set(input logic [1:0] src, input bit rst_en, input logic [3:0] oe_en);
    cv[GLB +: 2]   = src;
    cv[GLB+2]      = rst_en;
    cv[GLB+3 +: 4] = oe_en;
  endtask

  // Hold reset, write every word, release, let the synchroniser finish.
  task automatic load_cfg(input logic [17:0] din_rel);
    @(negedge clk_y0);
    rst_n = 1'b0;
    din   = din_rel;
    @(negedge clk_y0);
    for (int a = 0; a < N_WORDS; a++) begin
      cfg_we    = 1'b1;
      cfg_addr  = 6'(a);
      cfg_wdata = cv[a*32 +: 32];
      @(negedge clk_y0);
    end
    cfg_we = 1'b0;
  endtask

  task automatic release_rst();
    rst_n = 1'b1;
    repeat (3) @(negedge clk_y0);
  endtask

  task automatic pulse(ref logic c);
    #1 c = 1'b1;
    #1 c = 1'b0;
    #1;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; din = '0;

    // ---------------- Configuration A: combinational sums ----------------
    cv = '0;
    lit_on(0, 0, 0); lit_on(0, 1, 0);
    lit_on(1, 2, 1); lit_on(1, 3, 0);
    lit_on(2, 4, 0); lit_on(2, 5, 0); lit_on(2, 5, 1);
    lit_on(4, 6, 0); lit_on(4, 7, 0); lit_on(4, 8, 0);
    lit_on(5, 17, 0);
    lit_on(8, 9, 1); lit_on(8, 10, 1);
    lit_on(9, 11, 0);
    lit_on(12, 12, 0); lit_on(12, 13, 1);
    lit_on(13, 14, 0); lit_on(13, 15, 0); lit_on(13, 16, 0);
    lit_on(21, 15, 0);
    mc_set(0, 20'h0, 0, 0, 0);
    mc_set(1, 20'h80031, 1, 1, 0);
    mc_set(2, 20'h00100, 1, 0, 0);
    mc_set(3, 20'h0, 0, 0, 0);
    glb_set(2'd0, 0, 4'b1000);
    load_cfg(18'h0);
    release_rst();

    foreach (TBL[i]) begin
      din = TBL[i][25:8];
      #2;
      // R2 R3 R4 R8 R1 (literal order) R5 (combinational path)
      check($sformatf("R2_R3_R4_R8 vec%0d", i), {dout, dout_oe}, TBL[i][7:0]);
      @(negedge clk_y0);
    end

    // ---------------- Configuration B: registers, feedback, reset term ----
    cv = '0;
    lit_on(0, 0, 0);
    lit_on(4, 18, 0);
    lit_on(20, 17, 0);
    mc_set(0, 20'h0, 0, 0, 1);
    mc_set(1, 20'h00010, 1, 0, 1);
    mc_set(2, 20'h0, 0, 0, 0);
    mc_set(3, 20'h0, 1, 1, 1);
    glb_set(2'd0, 1, 4'b0000);
    load_cfg(18'h1);
    #2;
    check("R9 reset holds registers", {4'h0, dout}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk_y0);
    check("R9 release waits for sync", {4'h0, dout}, 8'h00);
    @(negedge clk_y0);
    din = 18'h0;
    @(negedge clk_y0);
    check("R5 polarity-one register captured", {4'h0, dout}, 8'h08);
    din = 18'h1;
    @(negedge clk_y0);
    check("R1 R6 shift stage 0", {4'h0, dout}, 8'h09);
    din = 18'h0;
    @(negedge clk_y0);
    check("R1 feedback stage 1", {4'h0, dout}, 8'h0A);
    @(negedge clk_y0);
    check("R1 feedback drained", {4'h0, dout}, 8'h08);
    din = 18'h20001;
    #2;
    check("R7 reset term clears at once", {4'h0, dout}, 8'h00);
    @(negedge clk_y0);
    check("R7 reset term holds through edge", {4'h0, dout}, 8'h00);
    din = 18'h00001;
    @(negedge clk_y0);
    check("R7 release resumes capture", {4'h0, dout}, 8'h09);
    cfg_we = 1'b1; cfg_addr = 6'd0; cfg_wdata = 32'h0;
    @(negedge clk_y0);
    cfg_we = 1'b0;
    @(negedge clk_y0);
    check("R10 write outside reset ignored", {4'h0, dout}, 8'h0B);

    // ---------------- Configuration C: dedicated clock 1 -----------------
    cv = '0;
    lit_on(0, 0, 0);
    mc_set(0, 20'h0, 0, 0, 1);
    glb_set(2'd1, 0, 4'b0000);
    load_cfg(18'h0);
    release_rst();
    din = 18'h1;
    repeat (2) @(negedge clk_y0);
    check("R6 y0 edges ignored when y1 selected", {4'h0, dout}, 8'h00);
    pulse(clk_y1);
    check("R6 y1 edge captures", {4'h0, dout}, 8'h01);
    din = 18'h0;
    pulse(clk_y2);
    check("R6 y2 edge ignored", {4'h0, dout}, 8'h01);
    pulse(clk_y1);
    check("R6 y1 edge captures zero", {4'h0, dout}, 8'h00);

    // ---------------- Configuration D: clock from term 22 ----------------
    cv = '0;
    lit_on(0, 0, 0);
    lit_on(22, 16, 0);
    mc_set(0, 20'h0, 0, 0, 1);
    glb_set(2'd3, 0, 4'b0000);
    load_cfg(18'h0);
    release_rst();
    din = 18'h00001;
    repeat (2) @(negedge clk_y0);
    check("R6 term clock idle no capture", {4'h0, dout}, 8'h00);
    din = 18'h10001;
    #2;
    check("R6 term clock rise captures", {4'h0, dout}, 8'h01);
    din = 18'h10000;
    #2;
    check("R6 term clock high no capture", {4'h0, dout}, 8'h01);
    din = 18'h00000;
    #2;
    check("R6 term clock fall no capture", {4'h0, dout}, 8'h01);
    din = 18'h10000;
    #2;
    check("R6 term clock second rise", {4'h0, dout}, 8'h00);

    finish_run();
  end

endmodule